// File: doc/BRIEF.md
# Single-Bus Processor Datapath with Hardwired Step Sequencer

This block is a compact processor core in which every register transfer goes over one shared internal bus. It holds a register file, a program counter, an instruction register, memory address and memory data registers, and two latches around the ALU: an operand latch in front of the ALU's A input and a result latch behind its output. The A input comes either from the operand latch or from a constant 4, and the B input always comes from the bus. A step counter with a combinational decoder produces every bus-drive and bus-load enable. No two registers ever drive the bus in the same step, so each transfer costs its own step. The program counter is advanced through the ALU by selecting the constant 4.

Instruction memory is reached through a read request and a completion input. The core raises its read request after the first fetch step and keeps it high until the completion input is seen. The second fetch step waits for that completion. While it waits, the step counter holds and no register loads. After the fetch, the sequencer runs the steps for one of five instructions: register add, subtract, exclusive-or, load of a sign-extended immediate, or relative branch. The last step of each instruction raises an end signal, and the counter then returns to step 1.

Instruction word (16 bits by default): opcode in bits [15:13], destination register Rd in [12:10], source register Rs in [9:7], and a 10-bit immediate or offset in [9:0]. The immediate is used only by instructions that have no Rs.

Top module: `sbus_cpu`

## Requirements
- R1: Fetch reads the word at the address held in PC. Step 1 sends PC to the address register and computes PC+4. The second fetch step loads PC+4 into PC and into the operand latch. Step 3 loads IR from the data register. For every instruction other than a branch, PC after the instruction equals PC before it plus 4.
- R2: The step output counts 1, 2, 3, ... and the end output is high in exactly one step. That step is step 4 for the immediate load and for unused opcodes, step 5 for a branch, and step 6 for the ALU opcodes. The step after the end step is step 1.
- R3: During fetch step 2, while the completion input is low, the step output stays at 2 and PC keeps its value. Step 2 lasts one cycle more than the number of cycles the memory takes to raise completion.
- R4: Opcode 000 (add) writes Rd+Rs into Rd, modulo 2^16, and leaves every other register unchanged. At most one source drives the internal bus in any cycle.
- R5: Opcode 001 (subtract) writes Rd-Rs into Rd, modulo 2^16. It uses the ALU carry-in with an inverted B operand. Rd equal to Rs gives 0.
- R6: Opcode 010 (exclusive-or) writes Rd XOR Rs into Rd.
- R7: Opcode 011 (branch) sets PC to the fetch address + 4 + the sign-extended offset [9:0]. This works for forward and backward offsets. An instruction that is jumped over changes no register.
- R8: Opcode 100 (immediate load) writes the sign-extended field [9:0] into Rd.
- R9: Opcodes 101, 110 and 111 change no register and advance PC by 4.
- R10: The read request rises on the cycle after step 1. It stays high, with the address equal to the fetch PC, until the cycle in which completion is high. The data register captures the memory data in that cycle.
- R11: While reset is active, and in the first cycle after it, the step output is 1 and PC, IR, all registers, the read request and the end output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 16 | Memory byte address (address register) |
| mem_rd | output | 1 | Read request, held until completion |
| mem_rdata | input | 16 | Memory read data |
| mem_mfc | input | 1 | Memory function complete |
| pc_o | output | 16 | Program counter |
| ir_o | output | 16 | Instruction register |
| step_o | output | 3 | Current control step |
| end_o | output | 1 | Last step of the current instruction |
| regs_o | output | 128 | Register file, register i in bits [16*i+15:16*i] |

## Verification
The bench varies the memory latency from zero to three cycles from one fetch to the next. A sequencer that ignored completion would leave step 2 early and load IR with stale data. A sequencer that let loads through during the wait would move PC before the read finished. Subtracting a register from itself and subtracting into a zero register expose a missing carry-in or a reversed operand order, because the result comes out off by one or with the wrong sign. The program contains a forward branch over an immediate load and a backward branch. A branch that skips sign extension, or that adds the offset to the fetch address instead of the incremented PC, lands on the wrong word, and the register and PC comparisons expose it.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  localparam logic [2:0] OPC_ADD = 3'd0;
  localparam logic [2:0] OPC_SUB = 3'd1;
  localparam logic [2:0] OPC_XOR = 3'd2;
  localparam logic [2:0] OPC_BR  = 3'd3;
  localparam logic [2:0] OPC_LDI = 3'd4;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_XOR = 2'd2
  } alu_e;

  typedef struct packed {
    logic pc_out;
    logic pc_in;
    logic mar_in;
    logic mem_read;
    logic sel4;
    logic z_in;
    logic z_out;
    logic y_in;
    logic wmfc;
    logic mdr_out;
    logic ir_in;
    logic off_out;
    logic rd_out;
    logic rs_out;
    logic rf_in;
    logic cin;
    logic done;
    alu_e alu;
  } ctrl_t;

endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  alu_e         op,
  output logic [W-1:0] y
);

  always_comb begin
    case (op)
      ALU_SUB: y = a + ~b + {{(W-1){1'b0}}, cin};
      ALU_XOR: y = a ^ b;
      default: y = a + b + {{(W-1){1'b0}}, cin};
    endcase
  end

endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int W    = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_i,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_idx,
  input  logic [RW-1:0]   rd_idx,
  input  logic [W-1:0]    bus_in,
  output logic [W-1:0]    rd_data,
  output logic [NREG*W-1:0] flat
);

  logic [W-1:0] r [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic ld;
    assign ld = wr_en && (wr_idx == RW'(i));
    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) r[i] <= '0;
      else if (ld) r[i] <= bus_in;
    end
    assign flat[i*W +: W] = r[i];
  end

  assign rd_data = r[rd_idx];

endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
#(
  parameter int STEPW = 3
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic [2:0]       opcode,
  input  logic             mfc,
  output ctrl_t            c,
  output logic [STEPW-1:0] step
);

  localparam logic [STEPW-1:0] S1 = STEPW'(1);
  localparam logic [STEPW-1:0] S2 = STEPW'(2);
  localparam logic [STEPW-1:0] S3 = STEPW'(3);
  localparam logic [STEPW-1:0] S4 = STEPW'(4);
  localparam logic [STEPW-1:0] S5 = STEPW'(5);
  localparam logic [STEPW-1:0] S6 = STEPW'(6);

  ctrl_t            raw;
  logic             stall;
  logic             alu_grp;
  logic [STEPW-1:0] step_nx;

  assign alu_grp = (opcode == OPC_ADD) || (opcode == OPC_SUB) || (opcode == OPC_XOR);

  always_comb begin
    raw     = '0;
    raw.alu = ALU_ADD;
    case (step)
      S1: begin
        raw.pc_out = 1'b1; raw.mar_in = 1'b1; raw.mem_read = 1'b1;
        raw.sel4   = 1'b1; raw.z_in   = 1'b1;
      end
      S2: begin
        raw.z_out = 1'b1; raw.pc_in = 1'b1; raw.y_in = 1'b1; raw.wmfc = 1'b1;
      end
      S3: begin
        raw.mdr_out = 1'b1; raw.ir_in = 1'b1;
      end
      default: begin
        if (alu_grp) begin
          if (step == S4) begin
            raw.rd_out = 1'b1; raw.y_in = 1'b1;
          end else if (step == S5) begin
            raw.rs_out = 1'b1; raw.z_in = 1'b1;
            raw.alu    = (opcode == OPC_SUB) ? ALU_SUB :
                         (opcode == OPC_XOR) ? ALU_XOR : ALU_ADD;
            raw.cin    = (opcode == OPC_SUB);
          end else begin
            raw.z_out = 1'b1; raw.rf_in = 1'b1; raw.done = 1'b1;
          end
        end else if (opcode == OPC_BR) begin
          if (step == S4) begin
            raw.off_out = 1'b1; raw.z_in = 1'b1;
          end else begin
            raw.z_out = 1'b1; raw.pc_in = 1'b1; raw.done = 1'b1;
          end
        end else if (opcode == OPC_LDI) begin
          raw.off_out = 1'b1; raw.rf_in = 1'b1; raw.done = 1'b1;
        end else begin
          raw.done = 1'b1;
        end
      end
    endcase
  end

  assign stall = raw.wmfc && !mfc;

  always_comb begin
    c = raw;
    if (stall) begin
      c.pc_in    = 1'b0;
      c.mar_in   = 1'b0;
      c.mem_read = 1'b0;
      c.z_in     = 1'b0;
      c.y_in     = 1'b0;
      c.ir_in    = 1'b0;
      c.rf_in    = 1'b0;
      c.done     = 1'b0;
    end
  end

  always_comb begin
    if (raw.done)   step_nx = S1;
    else if (stall) step_nx = step;
    else            step_nx = step + S1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) step <= S1;
    else        step <= step_nx;
  end

  // R3: the counter holds while waiting for completion
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (c.wmfc && !mfc) |=> (step == S2));

  // R2: after the end step the sequencer restarts at step 1
  p_end_restart_r2: assert property (@(posedge clk) disable iff (!rst_i)
    c.done |=> (step == S1));

  // R2: no instruction runs past step 6
  p_step_range_r2: assert property (@(posedge clk) disable iff (!rst_i)
    (step >= S1) && (step <= S6));

  // R4: at most one bus source per step
  p_one_driver_r4: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({c.pc_out, c.z_out, c.mdr_out, c.off_out, c.rd_out, c.rs_out}));

endmodule

// File: rtl/sbus_cpu.sv
module sbus_cpu
  import sbus_pkg::*;
#(
  parameter int W    = 16,
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [W-1:0]      mem_addr,
  output logic              mem_rd,
  input  logic [W-1:0]      mem_rdata,
  input  logic              mem_mfc,
  output logic [W-1:0]      pc_o,
  output logic [W-1:0]      ir_o,
  output logic [2:0]        step_o,
  output logic              end_o,
  output logic [NREG*W-1:0] regs_o
);

  localparam int RW   = $clog2(NREG);
  localparam int OPW  = 3;
  localparam int OFFW = W - OPW - RW;
  localparam int RD_HI = W - OPW - 1;
  localparam int RS_HI = W - OPW - RW - 1;

  logic rst_s1, rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  ctrl_t c;
  logic [W-1:0] pc, ir, mar, mdr, y, z;
  logic [W-1:0] pc_nx, ir_nx, mar_nx, mdr_nx, y_nx, z_nx;
  logic         rd_pend, rd_pend_nx;
  logic [W-1:0] bus, alu_a, alu_y, off_ext, rf_data;
  logic [RW-1:0] rd_f, rs_f, rf_ridx;
  logic         mdr_ext;

  assign rd_f    = ir[RD_HI -: RW];
  assign rs_f    = ir[RS_HI -: RW];
  assign off_ext = {{(W-OFFW){ir[OFFW-1]}}, ir[OFFW-1:0]};
  assign rf_ridx = c.rs_out ? rs_f : rd_f;

  sbus_ctrl #(.STEPW(3)) u_ctrl (
    .clk    (clk),
    .rst_i  (rst_i),
    .opcode (ir[W-1 -: OPW]),
    .mfc    (mem_mfc),
    .c      (c),
    .step   (step_o)
  );

  sbus_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_i   (rst_i),
    .wr_en   (c.rf_in),
    .wr_idx  (rd_f),
    .rd_idx  (rf_ridx),
    .bus_in  (bus),
    .rd_data (rf_data),
    .flat    (regs_o)
  );

  always_comb begin
    if (c.pc_out)                    bus = pc;
    else if (c.z_out)                bus = z;
    else if (c.mdr_out)              bus = mdr;
    else if (c.off_out)              bus = off_ext;
    else if (c.rd_out || c.rs_out)   bus = rf_data;
    else                             bus = '0;
  end

  assign alu_a = c.sel4 ? W'(4) : y;

  sbus_alu #(.W(W)) u_alu (
    .a   (alu_a),
    .b   (bus),
    .cin (c.cin),
    .op  (c.alu),
    .y   (alu_y)
  );

  assign mdr_ext = rd_pend && mem_mfc;

  always_comb begin
    pc_nx      = c.pc_in  ? bus   : pc;
    ir_nx      = c.ir_in  ? bus   : ir;
    mar_nx     = c.mar_in ? bus   : mar;
    y_nx       = c.y_in   ? bus   : y;
    z_nx       = c.z_in   ? alu_y : z;
    mdr_nx     = mdr_ext  ? mem_rdata : mdr;
    rd_pend_nx = c.mem_read ? 1'b1 : (mem_mfc ? 1'b0 : rd_pend);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pc      <= '0;
      ir      <= '0;
      mar     <= '0;
      mdr     <= '0;
      y       <= '0;
      z       <= '0;
      rd_pend <= 1'b0;
    end else begin
      pc      <= pc_nx;
      ir      <= ir_nx;
      mar     <= mar_nx;
      mdr     <= mdr_nx;
      y       <= y_nx;
      z       <= z_nx;
      rd_pend <= rd_pend_nx;
    end
  end

  assign mem_addr = mar;
  assign mem_rd   = rd_pend;
  assign pc_o     = pc;
  assign ir_o     = ir;
  assign end_o    = c.done;

  // R10: captured data equals the memory data of the completion cycle
  p_mdr_capture_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_pend && mem_mfc) |=> (mdr == $past(mem_rdata)));

  // R10: read request stays up until completion
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_pend && !mem_mfc) |=> (rd_pend && $stable(mar)));

  // R3: PC does not move while the fetch waits
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (c.wmfc && !mem_mfc) |=> $stable(pc));

endmodule

// File: tb/tb_sbus_cpu.sv
module tb_sbus_cpu;

  localparam int W = 16;
  localparam int NREG = 8;
  localparam int NINST = 14;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] mem_addr, mem_rdata, pc_o, ir_o;
  logic mem_rd, mem_mfc, end_o;
  logic [2:0] step_o;
  logic [NREG*W-1:0] regs_o;

  always #2 clk = ~clk;

  sbus_cpu #(.W(W), .NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_mfc(mem_mfc), .pc_o(pc_o), .ir_o(ir_o),
    .step_o(step_o), .end_o(end_o), .regs_o(regs_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] mem [32];
  int lat = 0;
  int mcnt = 0;

  assign mem_rdata = mem[mem_addr[6:2]];

  always @(negedge clk) begin
    if (mem_rd) begin
      if (mcnt >= lat) begin mem_mfc = 1'b1; mcnt = 0; end
      else begin mem_mfc = 1'b0; mcnt = mcnt + 1; end
    end else begin
      mem_mfc = 1'b0; mcnt = 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int rd, input int rs, input int off);
    logic [15:0] w;
    w = {op[2:0], rd[2:0], rs[2:0], 7'b0};
    w = w | {6'b0, off[9:0]};
    return w;
  endfunction

  function automatic logic [15:0] sx10(input logic [15:0] w);
    return {{6{w[9]}}, w[9:0]};
  endfunction

  logic [15:0] mr [NREG];

  task automatic check_regs(input string tag);
    for (int i = 0; i < NREG; i++) check(tag, regs_o[i*W +: W], mr[i]);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 16'h0;
    mem[0]  = enc(4, 1, 0, 5);
    mem[1]  = enc(4, 2, 0, -3);
    mem[2]  = enc(0, 1, 2, 0);
    mem[3]  = enc(1, 3, 1, 0);
    mem[4]  = enc(2, 2, 1, 0);
    mem[5]  = enc(3, 0, 0, 4);
    mem[6]  = enc(4, 4, 0, 99);
    mem[7]  = enc(0, 2, 2, 0);
    mem[8]  = enc(3, 0, 0, 8);
    mem[9]  = enc(4, 5, 0, 7);
    mem[10] = enc(3, 0, 0, 4);
    mem[11] = enc(3, 0, 0, -12);
    mem[12] = enc(7, 6, 0, 0);
    mem[13] = enc(0, 5, 1, 0);
    mem[14] = enc(1, 2, 2, 0);
  end

  initial begin
    logic [15:0] ep, eir;
    int op, rdi, rsi, last;
    string tg;
    rst_n = 1'b0;
    mem_mfc = 1'b0;
    for (int i = 0; i < NREG; i++) mr[i] = 16'h0;
    repeat (3) @(negedge clk);
    check("R11 step", step_o, 1);
    check("R11 pc", pc_o, 0);
    check("R11 rd", mem_rd, 0);
    check("R11 end", end_o, 0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R11 ir", ir_o, 0);
    check_regs("R11 regs");
    ep = 16'h0;
    for (int k = 0; k < NINST; k++) begin
      lat = k % 4;
      check("R2 step1", step_o, 1);
      check("R2 end low", end_o, 0);
      @(negedge clk);
      for (int s = 0; s <= lat; s++) begin
        check("R3 step2 hold", step_o, 2);
        check("R3 pc hold", pc_o, ep);
        check("R10 rd high", mem_rd, 1);
        check("R10 addr", mem_addr, ep);
        @(negedge clk);
      end
      check("R1 step3", step_o, 3);
      check("R10 rd low", mem_rd, 0);
      @(negedge clk);
      eir = mem[ep[6:2]];
      ep = ep + 16'd4;
      op = int'(eir[15:13]);
      rdi = int'(eir[12:10]);
      rsi = int'(eir[9:7]);
      case (op)
        0: begin mr[rdi] = mr[rdi] + mr[rsi]; last = 6; tg = "R4 add"; end
        1: begin mr[rdi] = mr[rdi] - mr[rsi]; last = 6; tg = "R5 sub"; end
        2: begin mr[rdi] = mr[rdi] ^ mr[rsi]; last = 6; tg = "R6 xor"; end
        3: begin ep = ep + sx10(eir); last = 5; tg = "R7 branch"; end
        4: begin mr[rdi] = sx10(eir); last = 4; tg = "R8 ldi"; end
        default: begin last = 4; tg = "R9 unused op"; end
      endcase
      for (int s = 4; s <= last; s++) begin
        check("R2 exec step", step_o, s);
        check("R2 end", end_o, (s == last) ? 1 : 0);
        @(negedge clk);
      end
      check({tg, " pc R1"}, pc_o, ep);
      check("R1 ir", ir_o, eir);
      check_regs(tg);
    end
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule